// File: doc/BRIEF.md
# SPI Command Slave with Opcode Decode

This block lets an external controller drive a measurement core over a four-wire serial link in SPI mode 0: data is sampled on the rising clock edge, shifted on the falling edge, and sent most significant bit first. All link pins are oversampled by the system clock, which must run at least eight times faster than the serial clock. A transaction is the period while chip select is low. It is cut into 16-bit words. The first word is the header, and its three top bits pick the operation.

While the header comes in, the block always shifts out the core's status word. By convention, bit 2 of that word tells the controller that fresh sample results are waiting, and bit 4 tells it that the sweep is halted.

The operations are:
- a register write;
- an identification read;
- a burst read of six 48-bit sample results;
- a burst read of six ADC limit words;
- a clear of those limits;
- a resume of a halted sweep;
- a six-word write of one sweep point's configuration.

Raising chip select at any moment ends the transaction. Nothing half-done reaches the core.

Every data path toward the core is a valid-only stream: `reg_wr_valid` and `cfg_wr_valid` are single-cycle strobes whose payload holds until the next strobe. There is no ready input, because the serial master cannot be stalled, so the core must accept every beat in the cycle it appears. The read buses `sample_bus` and `lim_bus` are sampled one word at a time, shortly after the previous word ends.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, every strobe output is low and `spi_miso` is low.
- R2: For every opcode, the 16 bits sent on `spi_miso` during the header are `status_word`, most significant bit first, starting when chip select falls.
- R3: Opcode 3'b010 returns the constant 16'hF0A5 as the second word.
- R4: Opcode 3'b100 raises `reg_wr_valid` for one cycle after the second word completes. `reg_wr_addr` is header bits 7:0 and `reg_wr_data` is the second word.
- R5: Opcode 3'b110 returns 18 data words after the header. Data word k (0..17) is `sample_bus[16k+15:16k]`. The bus holds six 48-bit slots in the order reference Q, reference I, port-2 Q, port-2 I, port-1 Q, port-1 I, so each slot is sent least significant word first.
- R6: `sample_ack` pulses once when the 18th data word of an opcode 3'b110 read completes, and never if that read ends earlier.
- R7: Opcode 3'b111 returns six data words, where word j is `lim_bus[16j+15:16j]` (port-1 max, port-1 min, port-2 max, port-2 min, reference max, reference min).
- R8: Opcode 3'b011 pulses `limits_clr` and opcode 3'b001 pulses `sweep_resume`, each once, when the header completes.
- R9: Opcode 3'b000 takes a point index from header bits 12:0, collects the next six words, and then pulses `cfg_wr_valid` once. The first collected word sits in `cfg_wr_data` bits 15:0, and the sixth in bits 95:80.
- R10: Raising chip select mid-transaction produces no strobe for the unfinished command, and the next transaction is decoded from a fresh header.
- R11: At most one strobe output is high in any cycle, and each strobe lasts a single cycle.
- R12: Words past the end of a command, and all words after a header with opcode 3'b101, are ignored and answered with zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| status_word | input | 16 | Core status, sent during every header |
| sample_bus | input | 288 | Six 48-bit sample results, in slot order |
| lim_bus | input | 96 | Six 16-bit ADC limit words |
| reg_wr_valid | output | 1 | Register write strobe |
| reg_wr_addr | output | 8 | Register address |
| reg_wr_data | output | 16 | Register value |
| cfg_wr_valid | output | 1 | Sweep-configuration write strobe |
| cfg_wr_point | output | 13 | Sweep point index |
| cfg_wr_data | output | 96 | Six configuration words |
| sample_ack | output | 1 | Sample burst fully read |
| limits_clr | output | 1 | Clear ADC limits |
| sweep_resume | output | 1 | Resume a halted sweep |

## Verification
The assertions assume the following about the inputs:
- the serial clock idles low and runs at most one eighth of the system clock;
- chip select changes only while the serial clock is low;
- every word takes at least 16 serial bits.

Under those conditions, the MISO line only moves on a falling serial edge or at the start of a transaction, and no two strobes can fall in the same or adjacent cycles.

The stimulus keeps to these limits by using one transfer task. It holds each half serial period for four system clocks, changes chip select only with the serial clock low, and waits twelve system clocks between transactions. It sweeps all eight opcodes, several addresses and point indices, and abort points placed inside a header, inside a data word and on word boundaries.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int unsigned OP_BITS = 3;

  typedef enum logic [OP_BITS-1:0] {
    OP_CFG_WR  = 3'b000,
    OP_RESUME  = 3'b001,
    OP_IDENT   = 3'b010,
    OP_LIM_CLR = 3'b011,
    OP_REG_WR  = 3'b100,
    OP_RSVD    = 3'b101,
    OP_SAMPLE  = 3'b110,
    OP_LIM_RD  = 3'b111
  } cmd_op_e;

  localparam logic [15:0] IDENT_WORD = 16'hF0A5;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_start,
  output logic mosi_s
);

  localparam int unsigned PINS = 3;
  localparam logic [PINS-1:0] IDLE = 3'b010;   // sclk low, cs_n high, mosi low

  logic [PINS-1:0] raw;
  logic [PINS-1:0] stg [STAGES];
  logic [PINS-1:0] last;

  assign raw = {sclk_i, cs_n_i, mosi_i};

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= IDLE;
          else        stg[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= IDLE;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= IDLE;
    else        last <= stg[STAGES-1];
  end

  logic sclk_s, cs_n_s;
  assign sclk_s    = stg[STAGES-1][2];
  assign cs_n_s    = stg[STAGES-1][1];
  assign mosi_s    = stg[STAGES-1][0];
  assign cs_act    = ~cs_n_s;
  assign cs_start  = ~cs_n_s & last[1];
  assign sclk_rise = ~cs_n_s & sclk_s & ~last[2];
  assign sclk_fall = ~cs_n_s & ~sclk_s & last[2];

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_act,
  input  logic         cs_start,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         mosi,
  input  logic [W-1:0] first_tx,
  input  logic [W-1:0] next_tx,
  output logic         miso,
  output logic         word_done,
  output logic [W-1:0] rx_word
);

  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [W-1:0]     rx_sh;
  logic [W-1:0]     tx_sh;
  logic [W-1:0]     rx_full;

  assign rx_full = {rx_sh[W-2:0], mosi};
  assign miso    = tx_sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_word   <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
      end else if (cs_start) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_sh   <= first_tx;
      end else begin
        if (sclk_rise) begin
          rx_sh <= rx_full;
          if (bit_cnt == LAST_BIT) begin
            bit_cnt   <= '0;
            word_done <= 1'b1;
            rx_word   <= rx_full;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (sclk_fall) begin
          // a falling edge with the counter at zero follows a finished word
          if (bit_cnt == '0) tx_sh <= next_tx;
          else               tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_cmd_pkg::*;
#(
  parameter int unsigned W            = 16,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned POINT_W      = 13,
  parameter int unsigned CFG_WORDS    = 6,
  parameter int unsigned SAMPLE_SLOTS = 6,
  parameter int unsigned SAMPLE_W     = 48,
  parameter int unsigned LIM_WORDS    = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cs_act,
  input  logic                           word_done,
  input  logic [W-1:0]                   rx_word,
  input  logic [SAMPLE_SLOTS*SAMPLE_W-1:0] sample_bus,
  input  logic [LIM_WORDS*W-1:0]         lim_bus,
  output logic [W-1:0]                   next_tx,
  output logic                           reg_wr_valid,
  output logic [ADDR_W-1:0]              reg_wr_addr,
  output logic [W-1:0]                   reg_wr_data,
  output logic                           cfg_wr_valid,
  output logic [POINT_W-1:0]             cfg_wr_point,
  output logic [CFG_WORDS*W-1:0]         cfg_wr_data,
  output logic                           sample_ack,
  output logic                           limits_clr,
  output logic                           sweep_resume
);

  localparam int unsigned SAMPLE_WORDS = SAMPLE_SLOTS * SAMPLE_W / W;
  localparam int unsigned CFG_BITS     = CFG_WORDS * W;
  localparam int unsigned MAX_A        = (SAMPLE_WORDS > CFG_WORDS) ? SAMPLE_WORDS : CFG_WORDS;
  localparam int unsigned MAX_IDX      = (MAX_A > LIM_WORDS) ? MAX_A : LIM_WORDS;
  localparam int unsigned IDX_W        = $clog2(MAX_IDX + 2);
  localparam logic [IDX_W-1:0] SAT_IDX     = IDX_W'(MAX_IDX + 1);
  localparam logic [IDX_W-1:0] LAST_SAMPLE = IDX_W'(SAMPLE_WORDS);
  localparam logic [IDX_W-1:0] LAST_CFG    = IDX_W'(CFG_WORDS);
  localparam logic [IDX_W-1:0] LAST_LIM    = IDX_W'(LIM_WORDS);
  localparam logic [IDX_W-1:0] ONE         = IDX_W'(1);

  cmd_op_e          op_q;
  logic [W-1:0]     hdr_q;
  logic [IDX_W-1:0] widx;
  logic [CFG_BITS-1:0] cfg_buf;

  cmd_op_e          cur_op;
  logic [IDX_W-1:0] nxt_idx;
  logic [IDX_W-1:0] slot;
  logic [W-1:0]     tx_sel;
  logic [CFG_BITS-1:0] cfg_shift;

  assign cur_op    = (widx == '0) ? cmd_op_e'(rx_word[W-1 -: OP_BITS]) : op_q;
  assign nxt_idx   = (widx == SAT_IDX) ? SAT_IDX : widx + 1'b1;
  assign slot      = nxt_idx - ONE;
  assign cfg_shift = {rx_word, cfg_buf[CFG_BITS-1:W]};

  // word returned after the one just finished
  always_comb begin
    tx_sel = '0;
    unique case (cur_op)
      OP_IDENT:  if (nxt_idx == ONE) tx_sel = W'(IDENT_WORD);
      OP_SAMPLE: if (nxt_idx >= ONE && nxt_idx <= LAST_SAMPLE)
                   tx_sel = sample_bus[slot*W +: W];
      OP_LIM_RD: if (nxt_idx >= ONE && nxt_idx <= LAST_LIM)
                   tx_sel = lim_bus[slot*W +: W];
      default:   tx_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q         <= OP_RSVD;
      hdr_q        <= '0;
      widx         <= '0;
      cfg_buf      <= '0;
      next_tx      <= '0;
      reg_wr_valid <= 1'b0;
      reg_wr_addr  <= '0;
      reg_wr_data  <= '0;
      cfg_wr_valid <= 1'b0;
      cfg_wr_point <= '0;
      cfg_wr_data  <= '0;
      sample_ack   <= 1'b0;
      limits_clr   <= 1'b0;
      sweep_resume <= 1'b0;
    end else begin
      reg_wr_valid <= 1'b0;
      cfg_wr_valid <= 1'b0;
      sample_ack   <= 1'b0;
      limits_clr   <= 1'b0;
      sweep_resume <= 1'b0;
      if (!cs_act) begin
        widx <= '0;
      end else if (word_done) begin
        widx    <= nxt_idx;
        next_tx <= tx_sel;
        if (widx == '0) begin
          op_q         <= cur_op;
          hdr_q        <= rx_word;
          limits_clr   <= (cur_op == OP_LIM_CLR);
          sweep_resume <= (cur_op == OP_RESUME);
        end else begin
          unique case (op_q)
            OP_REG_WR: if (widx == ONE) begin
              reg_wr_valid <= 1'b1;
              reg_wr_addr  <= hdr_q[ADDR_W-1:0];
              reg_wr_data  <= rx_word;
            end
            OP_CFG_WR: if (widx <= LAST_CFG) begin
              cfg_buf <= cfg_shift;
              if (widx == LAST_CFG) begin
                cfg_wr_valid <= 1'b1;
                cfg_wr_point <= hdr_q[POINT_W-1:0];
                cfg_wr_data  <= cfg_shift;
              end
            end
            OP_SAMPLE: if (widx == LAST_SAMPLE) sample_ack <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned POINT_W      = 13,
  parameter int unsigned CFG_WORDS    = 6,
  parameter int unsigned SAMPLE_SLOTS = 6,
  parameter int unsigned SAMPLE_W     = 48,
  parameter int unsigned LIM_WORDS    = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               spi_sclk,
  input  logic                               spi_cs_n,
  input  logic                               spi_mosi,
  output logic                               spi_miso,
  input  logic [WORD_W-1:0]                  status_word,
  input  logic [SAMPLE_SLOTS*SAMPLE_W-1:0]   sample_bus,
  input  logic [LIM_WORDS*WORD_W-1:0]        lim_bus,
  output logic                               reg_wr_valid,
  output logic [ADDR_W-1:0]                  reg_wr_addr,
  output logic [WORD_W-1:0]                  reg_wr_data,
  output logic                               cfg_wr_valid,
  output logic [POINT_W-1:0]                 cfg_wr_point,
  output logic [CFG_WORDS*WORD_W-1:0]        cfg_wr_data,
  output logic                               sample_ack,
  output logic                               limits_clr,
  output logic                               sweep_resume
);

  logic sclk_rise, sclk_fall, cs_act, cs_start, mosi_s;
  logic word_done;
  logic [WORD_W-1:0] rx_word, next_tx;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (spi_sclk),
    .cs_n_i    (spi_cs_n),
    .mosi_i    (spi_mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .cs_start  (cs_start),
    .mosi_s    (mosi_s)
  );

  spi_word_engine #(.W(WORD_W)) u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .cs_start  (cs_start),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi      (mosi_s),
    .first_tx  (status_word),
    .next_tx   (next_tx),
    .miso      (spi_miso),
    .word_done (word_done),
    .rx_word   (rx_word)
  );

  spi_cmd_fsm #(
    .W            (WORD_W),
    .ADDR_W       (ADDR_W),
    .POINT_W      (POINT_W),
    .CFG_WORDS    (CFG_WORDS),
    .SAMPLE_SLOTS (SAMPLE_SLOTS),
    .SAMPLE_W     (SAMPLE_W),
    .LIM_WORDS    (LIM_WORDS)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_act       (cs_act),
    .word_done    (word_done),
    .rx_word      (rx_word),
    .sample_bus   (sample_bus),
    .lim_bus      (lim_bus),
    .next_tx      (next_tx),
    .reg_wr_valid (reg_wr_valid),
    .reg_wr_addr  (reg_wr_addr),
    .reg_wr_data  (reg_wr_data),
    .cfg_wr_valid (cfg_wr_valid),
    .cfg_wr_point (cfg_wr_point),
    .cfg_wr_data  (cfg_wr_data),
    .sample_ack   (sample_ack),
    .limits_clr   (limits_clr),
    .sweep_resume (sweep_resume)
  );

endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic cs_start,
  input logic sclk_fall,
  input logic word_done,
  input logic spi_miso,
  input logic reg_wr_valid,
  input logic cfg_wr_valid,
  input logic sample_ack,
  input logic limits_clr,
  input logic sweep_resume
);

  logic any_strobe;
  assign any_strobe = reg_wr_valid | cfg_wr_valid | sample_ack | limits_clr | sweep_resume;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_valid, cfg_wr_valid, sample_ack, limits_clr, sweep_resume})); // R11

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> !any_strobe); // R11

  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !sclk_fall && !cs_start) |=> $stable(spi_miso)); // R2

  AST_REGWR_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid |-> $past(word_done) && $past(cs_act)); // R4

  AST_HDR_CMD_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (limits_clr || sweep_resume) |-> $past(word_done)); // R8

  AST_CFG_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_valid |-> $past(word_done) && $past(cs_act)); // R10

  AST_ACK_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ack |-> $past(word_done) && $past(cs_act)); // R6

endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_act       (cs_act),
  .cs_start     (cs_start),
  .sclk_fall    (sclk_fall),
  .word_done    (word_done),
  .spi_miso     (spi_miso),
  .reg_wr_valid (reg_wr_valid),
  .cfg_wr_valid (cfg_wr_valid),
  .sample_ack   (sample_ack),
  .limits_clr   (limits_clr),
  .sweep_resume (sweep_resume)
);

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;

  localparam int HP = 4;   // system clocks per serial half period

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [15:0]  status_word = '0;
  logic [287:0] sample_bus = '0;
  logic [95:0]  lim_bus = '0;
  logic         reg_wr_valid, cfg_wr_valid, sample_ack, limits_clr, sweep_resume;
  logic [7:0]   reg_wr_addr;
  logic [15:0]  reg_wr_data;
  logic [12:0]  cfg_wr_point;
  logic [95:0]  cfg_wr_data;

  spi_cmd_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .status_word(status_word),
    .sample_bus(sample_bus), .lim_bus(lim_bus),
    .reg_wr_valid(reg_wr_valid), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .cfg_wr_valid(cfg_wr_valid), .cfg_wr_point(cfg_wr_point), .cfg_wr_data(cfg_wr_data),
    .sample_ack(sample_ack), .limits_clr(limits_clr), .sweep_resume(sweep_resume)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int n_reg = 0, n_cfg = 0, n_ack = 0, n_clr = 0, n_res = 0;
  logic [15:0] mo [20];
  logic [15:0] mi [20];

  always @(negedge clk) if (rst_n) begin
    if (reg_wr_valid) n_reg++;
    if (cfg_wr_valid) n_cfg++;
    if (sample_ack)   n_ack++;
    if (limits_clr)   n_clr++;
    if (sweep_resume) n_res++;
  end

  function automatic logic [15:0] sw(int k);
    return 16'((k * 16'h0F1D) ^ 16'hB400);
  endfunction
  function automatic logic [15:0] lw(int j);
    return 16'(16'h8000 - j * 16'h0123);
  endfunction

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(int nbits);
    for (int i = 0; i < 20; i++) mi[i] = '0;
    spi_cs_n = 1'b0;
    clks(HP);
    for (int b = 0; b < nbits; b++) begin
      spi_mosi = mo[b/16][15 - (b % 16)];
      mi[b/16][15 - (b % 16)] = spi_miso;
      spi_sclk = 1'b1;
      clks(HP);
      spi_sclk = 1'b0;
      clks(HP);
    end
    clks(HP);
    spi_cs_n = 1'b1;
    clks(2 * HP + 4);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int r0, c0, a0, l0, s0;
    for (int k = 0; k < 18; k++) sample_bus[k*16 +: 16] = sw(k);
    for (int j = 0; j < 6; j++)  lim_bus[j*16 +: 16] = lw(j);
    clks(3);
    // R1: reset state
    chk("R1 strobes", {reg_wr_valid, cfg_wr_valid, sample_ack, limits_clr, sweep_resume}, '0);
    chk("R1 miso", spi_miso, 1'b0);
    rst_n = 1'b1;
    clks(4);

    // opcode sweep: status header, second word, strobes
    for (int op = 0; op < 8; op++) begin
      status_word = 16'((16'h1234 ^ (op * 16'h1111)) | ((op & 1) << 2) | ((op & 2) << 3));
      mo[0] = {3'(op), 13'h00AA};
      mo[1] = 16'h5A5A;
      r0 = n_reg; c0 = n_cfg; a0 = n_ack; l0 = n_clr; s0 = n_res;
      xfer(32);
      chk("R2 status header", mi[0], status_word);
      case (op)
        2: chk("R3 ident word", mi[1], 16'hF0A5);
        6: chk("R5 first sample word", mi[1], sw(0));
        7: chk("R7 first limit word", mi[1], lw(0));
        default: chk("R12 zero fill", mi[1], 16'h0000);
      endcase
      chk("R8 limits_clr count", n_clr - l0, (op == 3) ? 1 : 0);
      chk("R8 sweep_resume count", n_res - s0, (op == 1) ? 1 : 0);
      chk("R4 reg write count", n_reg - r0, (op == 4) ? 1 : 0);
      chk("R10 no partial cfg/ack", (n_cfg - c0) + (n_ack - a0), 0);
    end

    // register writes across address corners, with a trailing extra word
    for (int i = 0; i < 4; i++) begin
      logic [7:0] ad;
      ad = (i == 0) ? 8'h00 : (i == 1) ? 8'h01 : (i == 2) ? 8'h7F : 8'hFF;
      mo[0] = {3'b100, 5'b10101, ad};
      mo[1] = 16'(16'hC0DE + i * 16'h1357);
      mo[2] = 16'hFFFF;
      r0 = n_reg;
      xfer(48);
      chk("R4 reg addr", reg_wr_addr, ad);
      chk("R4 reg data", reg_wr_data, mo[1]);
      chk("R12 single reg strobe", n_reg - r0, 1);
      chk("R12 trailing word zero", mi[2], 16'h0000);
    end

    // full sample burst
    status_word = 16'h0014;
    mo[0] = 16'hC000;
    for (int k = 1; k < 20; k++) mo[k] = 16'h0000;
    a0 = n_ack;
    xfer(19 * 16);
    chk("R2 status on sample read", mi[0], 16'h0014);
    for (int k = 0; k < 18; k++) chk("R5 sample word", mi[k+1], sw(k));
    chk("R6 ack once", n_ack - a0, 1);

    // aborted sample bursts
    a0 = n_ack;
    xfer(18 * 16);
    chk("R6 no ack at 17 data words", n_ack - a0, 0);
    xfer(19 * 16 - 4);
    chk("R6 no ack mid last word", n_ack - a0, 0);

    // limits read with extra word
    mo[0] = 16'hE000;
    xfer(8 * 16);
    for (int j = 0; j < 6; j++) chk("R7 limit word", mi[j+1], lw(j));
    chk("R12 past limits zero", mi[7], 16'h0000);

    // sweep configuration writes
    for (int p = 0; p < 4; p++) begin
      logic [12:0] pt;
      logic [95:0] exp;
      pt = (p == 0) ? 13'h0000 : (p == 1) ? 13'h0001 : (p == 2) ? 13'h1FFF : 13'h0ABC;
      mo[0] = {3'b000, pt};
      for (int w = 1; w <= 8; w++) mo[w] = 16'(w * 16'h1111 + p);
      for (int w = 0; w < 6; w++) exp[w*16 +: 16] = mo[w+1];
      c0 = n_cfg;
      xfer((p == 3) ? 9 * 16 : 7 * 16);
      chk("R9 cfg point", cfg_wr_point, pt);
      chk("R9 cfg data", cfg_wr_data, exp);
      chk("R12 single cfg write", n_cfg - c0, 1);
    end

    // aborts followed by fresh commands
    mo[0] = 16'h0123;
    c0 = n_cfg;
    xfer(7 * 16 - 1);
    chk("R10 cfg abort no write", n_cfg - c0, 0);
    mo[0] = 16'h0123;
    xfer(6 * 16);
    chk("R10 cfg abort at boundary", n_cfg - c0, 0);
    mo[0] = {3'b100, 5'b0, 8'h3C};
    mo[1] = 16'hBEEF;
    r0 = n_reg;
    xfer(20);
    chk("R10 reg abort no write", n_reg - r0, 0);
    l0 = n_clr;
    mo[0] = 16'h6000;
    xfer(10);
    chk("R10 header abort no clear", n_clr - l0, 0);
    mo[0] = {3'b100, 5'b0, 8'h5D};
    mo[1] = 16'h2468;
    xfer(32);
    chk("R10 fresh header addr", reg_wr_addr, 8'h5D);
    chk("R10 fresh header data", reg_wr_data, 16'h2468);
    chk("R10 fresh header count", n_reg - r0, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule